// File: doc/BRIEF.md
# PCM Codec Serial Port

This block links a telephony codec to a host over a full-duplex bit-serial path. It makes the shift clock and a frame marker. It sends bytes taken from a transmit queue and fills a receive queue with bytes it gathers from the data input. Each queue holds sixteen bytes. The host writes the transmit queue and reads the receive queue one byte at a time. It services both queues on a single interrupt, which fires each time eight bytes have moved through either queue.

The shift clock comes from a strobe supplied by an external prescaler. Each strobe moves the shift clock by one half period. With the strobe at 128 kHz, the link runs at 64 kbit/s in each direction, and eight-bit frames arrive at 8 kHz. The interrupt then comes once per millisecond. A global enable switches the whole block on. Two further enables, one for receive and one for transmit, must both be set before the serial side moves.

Top module: `pcm_codec_port`

## Requirements
- R1: While `enable` is low, both queues are empty, host writes and reads are ignored, the interrupt and both error flags are clear, and all serial outputs are low.
- R2: Each queue is 16 bytes deep and reports its fill level. A write to a full transmit queue is discarded.
- R3: While active, `pcm_clk` changes state on each `bit_tick`, so one bit period spans two strobes. Active means `enable`, `rx_enable` and `tx_enable` are all high.
- R4: If `rx_enable` or `tx_enable` is low, the serial outputs stay low and no byte moves. Queue contents are kept and remain reachable from the host.
- R5: After activation, the first bit period is a lead-in that carries no data. `pcm_dout` is 0 during the lead-in, and `pcm_sync` is high. Frames of 8 bits follow, sent MSB first, with `pcm_dout` updated on each rise of `pcm_clk`. `pcm_sync` is high for exactly the bit period before each MSB, which is the lead-in or the previous frame's LSB period.
- R6: `pcm_din` is sampled on each fall of `pcm_clk` during data periods. After the eighth sample of a frame, the byte (first sample = MSB) is appended to the receive queue. `rx_rdata` always shows the oldest stored byte.
- R7: If the transmit queue is empty when a frame starts, the frame carries 0xFF and `tx_underrun` is set and stays set.
- R8: If the receive queue is full when a byte completes, that byte is dropped and `rx_overflow` is set and stays set.
- R9: `irq` rises when a received byte brings the receive level to 8, or when a transmitted byte brings the transmit level down to 8. It stays high until the level of the queue that raised it moves past 8 (below 8 for receive, above 8 for transmit) or `irq_ack` is pulsed.
- R10: `irq_ack` clears `irq`, `tx_underrun` and `rx_overflow`. A new setting event in the same cycle wins over the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Global enable; low clears the block |
| rx_enable | input | 1 | Receive enable |
| tx_enable | input | 1 | Transmit enable |
| bit_tick | input | 1 | Half-bit strobe from the prescaler |
| tx_wr | input | 1 | Push `tx_wdata` into the transmit queue |
| tx_wdata | input | 8 | Byte to transmit |
| tx_level | output | 5 | Transmit queue fill level |
| rx_rd | input | 1 | Pop the oldest received byte |
| rx_rdata | output | 8 | Oldest received byte |
| rx_level | output | 5 | Receive queue fill level |
| irq | output | 1 | Queue service interrupt |
| irq_ack | input | 1 | Clears interrupt and error flags |
| tx_underrun | output | 1 | Sticky transmit underrun flag |
| rx_overflow | output | 1 | Sticky receive overflow flag |
| pcm_clk | output | 1 | Serial shift clock |
| pcm_sync | output | 1 | Frame sync |
| pcm_dout | output | 1 | Serial data out |
| pcm_din | input | 1 | Serial data in |

## Verification
The assertions take `bit_tick` to be a single-cycle pulse, spaced at least two clocks apart. That keeps every half period of `pcm_clk` at least one clock long. They also take `irq_ack` to be a pulse that is driven only while `enable` is high.

The stimulus fires the strobe every fourth clock. It drives `pcm_din` from a shift-register sequence that changes every clock, so the sampling edge is what picks each bit. It pulses acknowledge only once the block is enabled. It also drops the enables in the middle of a frame, which exercises the lead-in on restart.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

  localparam int unsigned BYTE_W = 8;

  // set wins over clear; otherwise hold
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // fill level after one cycle of accepted push/pop
  function automatic int unsigned level_after(input int unsigned lvl, input logic push, input logic pop);
    return lvl + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

endpackage

// File: rtl/pcm_fifo.sv
module pcm_fifo
  import pcm_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clr,
  input  logic                           wr,
  input  logic [W-1:0]                   wdata,
  input  logic                           rd,
  output logic [W-1:0]                   rdata,
  output logic [$clog2(DEPTH+1)-1:0]     level,
  output logic [$clog2(DEPTH+1)-1:0]     level_nxt,
  output logic                           full
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [LW-1:0] cnt;

  wire empty = (cnt == '0);
  wire wr_ok = wr & ~full;
  wire rd_ok = rd & ~empty;

  assign full      = (cnt == LW'(DEPTH));
  assign level     = cnt;
  assign level_nxt = LW'(level_after(int'(cnt), wr_ok, rd_ok));
  assign rdata     = mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (clr) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (wr_ok) wptr <= wptr + AW'(1);
      if (rd_ok) rptr <= rptr + AW'(1);
      cnt <= level_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok && !clr) mem[wptr] <= wdata;
  end

  p_level_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LW'(DEPTH));

  p_level_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == $past(cnt)) || (cnt == $past(cnt) + LW'(1)) ||
    (cnt + LW'(1) == $past(cnt)) || (cnt == '0));

endmodule

// File: rtl/pcm_serdes.sv
module pcm_serdes #(
  parameter int unsigned BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic            tick,
  input  logic [BITS-1:0] tx_byte,
  input  logic            tx_avail,
  input  logic            din,
  output logic            pcm_clk,
  output logic            pcm_sync,
  output logic            pcm_dout,
  output logic            tx_pop,
  output logic            underrun_ev,
  output logic            rx_push,
  output logic [BITS-1:0] rx_byte
);
  localparam int SW = $clog2(BITS);
  localparam logic [SW-1:0] LAST = SW'(BITS - 1);
  localparam logic [SW-1:0] PRE  = SW'(BITS - 2);

  logic            sclk_q, sync_q, dout_q, primed_q;
  logic [SW-1:0]   slot_q;
  logic [BITS-1:0] tx_sh, rx_sh;

  // named internal events
  wire rise_ev     = active & tick & ~sclk_q;
  wire fall_ev     = active & tick &  sclk_q;
  wire [SW-1:0] slot_n = slot_q + SW'(1);
  wire frame_start = rise_ev & (slot_n == '0);
  wire [BITS-1:0] load = tx_avail ? tx_byte : '1;
  wire [BITS-1:0] rx_word = {rx_sh[BITS-2:0], din};

  assign tx_pop      = frame_start & tx_avail;
  assign underrun_ev = frame_start & ~tx_avail;
  assign rx_push     = fall_ev & primed_q & (slot_q == LAST);
  assign rx_byte     = rx_word;
  assign pcm_clk     = sclk_q;
  assign pcm_sync    = sync_q;
  assign pcm_dout    = dout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0; sync_q <= 1'b0; dout_q <= 1'b0; primed_q <= 1'b0;
      slot_q <= PRE;  tx_sh  <= '0;   rx_sh  <= '0;
    end else if (!active) begin
      sclk_q <= 1'b0; sync_q <= 1'b0; dout_q <= 1'b0; primed_q <= 1'b0;
      slot_q <= PRE;  tx_sh  <= '0;   rx_sh  <= '0;
    end else begin
      if (rise_ev) begin
        sclk_q <= 1'b1;
        slot_q <= slot_n;
        sync_q <= (slot_n == LAST);
        if (slot_n == '0) begin
          primed_q <= 1'b1;
          dout_q   <= load[BITS-1];
          tx_sh    <= {load[BITS-2:0], 1'b0};
        end else begin
          dout_q <= tx_sh[BITS-1];
          tx_sh  <= {tx_sh[BITS-2:0], 1'b0};
        end
      end
      if (fall_ev) begin
        sclk_q <= 1'b0;
        rx_sh  <= rx_word;
      end
    end
  end

  p_clk_follows_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tick) |=> (pcm_clk != $past(pcm_clk)));

  p_idle_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!pcm_clk && !pcm_sync && !pcm_dout));

  p_sync_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pcm_sync) |-> pcm_clk);

  p_push_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !pcm_clk);

endmodule

// File: rtl/pcm_irq_ctrl.sv
module pcm_irq_ctrl
  import pcm_pkg::*;
#(
  parameter int unsigned LW   = 5,
  parameter int unsigned HALF = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ack,
  input  logic          rx_push_ok,
  input  logic [LW-1:0] rx_level_nxt,
  input  logic          tx_pop,
  input  logic [LW-1:0] tx_level_nxt,
  input  logic          underrun_ev,
  input  logic          overflow_ev,
  output logic          irq,
  output logic          tx_underrun,
  output logic          rx_overflow
);
  localparam logic [LW-1:0] HALF_L = LW'(HALF);

  logic irq_rx_q, irq_tx_q, und_q, ovf_q;

  wire rx_set = rx_push_ok & (rx_level_nxt == HALF_L);
  wire tx_set = tx_pop     & (tx_level_nxt == HALF_L);
  wire rx_clr = ack | (rx_level_nxt < HALF_L);
  wire tx_clr = ack | (tx_level_nxt > HALF_L);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_rx_q <= 1'b0; irq_tx_q <= 1'b0; und_q <= 1'b0; ovf_q <= 1'b0;
    end else if (clr) begin
      irq_rx_q <= 1'b0; irq_tx_q <= 1'b0; und_q <= 1'b0; ovf_q <= 1'b0;
    end else begin
      irq_rx_q <= sticky_next(irq_rx_q, rx_set, rx_clr);
      irq_tx_q <= sticky_next(irq_tx_q, tx_set, tx_clr);
      und_q    <= sticky_next(und_q, underrun_ev, ack);
      ovf_q    <= sticky_next(ovf_q, overflow_ev, ack);
    end
  end

  assign irq         = irq_rx_q | irq_tx_q;
  assign tx_underrun = und_q;
  assign rx_overflow = ovf_q;

  p_irq_has_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(rx_set) || $past(tx_set)));

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tx_underrun) && !$past(ack) && !$past(clr)) |-> tx_underrun);

  p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !overflow_ev) |=> !rx_overflow);

endmodule

// File: rtl/pcm_codec_port.sv
module pcm_codec_port
  import pcm_pkg::*;
#(
  parameter int unsigned DATA_W = BYTE_W,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned LW    = $clog2(DEPTH + 1),
  localparam int unsigned HALF  = DEPTH / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              rx_enable,
  input  logic              tx_enable,
  input  logic              bit_tick,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_wdata,
  output logic [LW-1:0]     tx_level,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_rdata,
  output logic [LW-1:0]     rx_level,
  output logic              irq,
  input  logic              irq_ack,
  output logic              tx_underrun,
  output logic              rx_overflow,
  output logic              pcm_clk,
  output logic              pcm_sync,
  output logic              pcm_dout,
  input  logic              pcm_din
);
  wire link_on = enable & rx_enable & tx_enable;
  wire clr_all = ~enable;

  logic [DATA_W-1:0] tx_head, rx_word;
  logic [LW-1:0]     tx_lvl_nxt, rx_lvl_nxt;
  logic              tx_full, rx_full;
  logic              tx_pop, underrun_ev, rx_push;

  wire tx_avail   = (tx_level != '0);
  wire rx_push_ok = rx_push & ~rx_full;
  wire rx_drop    = rx_push &  rx_full;

  pcm_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .clr(clr_all),
    .wr(tx_wr & enable), .wdata(tx_wdata),
    .rd(tx_pop), .rdata(tx_head),
    .level(tx_level), .level_nxt(tx_lvl_nxt), .full(tx_full)
  );

  pcm_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .clr(clr_all),
    .wr(rx_push), .wdata(rx_word),
    .rd(rx_rd & enable), .rdata(rx_rdata),
    .level(rx_level), .level_nxt(rx_lvl_nxt), .full(rx_full)
  );

  pcm_serdes #(.BITS(DATA_W)) u_serdes (
    .clk(clk), .rst_n(rst_n), .active(link_on), .tick(bit_tick),
    .tx_byte(tx_head), .tx_avail(tx_avail), .din(pcm_din),
    .pcm_clk(pcm_clk), .pcm_sync(pcm_sync), .pcm_dout(pcm_dout),
    .tx_pop(tx_pop), .underrun_ev(underrun_ev),
    .rx_push(rx_push), .rx_byte(rx_word)
  );

  pcm_irq_ctrl #(.LW(LW), .HALF(HALF)) u_irq (
    .clk(clk), .rst_n(rst_n), .clr(clr_all), .ack(irq_ack),
    .rx_push_ok(rx_push_ok), .rx_level_nxt(rx_lvl_nxt),
    .tx_pop(tx_pop), .tx_level_nxt(tx_lvl_nxt),
    .underrun_ev(underrun_ev), .overflow_ev(rx_drop),
    .irq(irq), .tx_underrun(tx_underrun), .rx_overflow(rx_overflow)
  );

  p_underrun_sends_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_ev |=> (pcm_dout && tx_underrun));

  p_drop_only_when_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |-> (rx_level == LW'(DEPTH)));

  p_disabled_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (tx_level == '0 && rx_level == '0 && !irq));

endmodule

// File: tb/tb_pcm_codec_port.sv
module tb_pcm_codec_port;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int QDEPTH     = 16;
  localparam int QHALF      = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 0, rx_enable = 0, tx_enable = 0, bit_tick = 0;
  logic tx_wr = 0, rx_rd = 0, irq_ack = 0, pcm_din = 0;
  logic [7:0] tx_wdata = '0;
  logic [4:0] tx_level, rx_level;
  logic [7:0] rx_rdata;
  logic irq, tx_underrun, rx_overflow, pcm_clk, pcm_sync, pcm_dout;

  pcm_codec_port dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rx_enable(rx_enable),
    .tx_enable(tx_enable), .bit_tick(bit_tick), .tx_wr(tx_wr),
    .tx_wdata(tx_wdata), .tx_level(tx_level), .rx_rd(rx_rd),
    .rx_rdata(rx_rdata), .rx_level(rx_level), .irq(irq), .irq_ack(irq_ack),
    .tx_underrun(tx_underrun), .rx_overflow(rx_overflow),
    .pcm_clk(pcm_clk), .pcm_sync(pcm_sync), .pcm_dout(pcm_dout),
    .pcm_din(pcm_din)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  logic [7:0] m_txq[$];
  logic [7:0] m_rxq[$];
  int   m_k = 0;
  logic m_sclk = 0, m_sync = 0, m_dout = 0;
  logic m_irq_rx = 0, m_irq_tx = 0, m_und = 0, m_ovf = 0;
  logic [7:0] m_cur = 0, m_rxb = 0;
  logic [15:0] lfsr = 16'hACE1;

  int vectors = 0, fails = 0, cyc = 0;
  bit done = 0;

  task automatic check1(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic compare_all();
    check1("R3", "pcm_clk",  int'(pcm_clk),  int'(m_sclk));
    check1("R5", "pcm_sync", int'(pcm_sync), int'(m_sync));
    check1("R5", "pcm_dout", int'(pcm_dout), int'(m_dout));
    check1("R2", "tx_level", int'(tx_level), m_txq.size());
    check1("R6", "rx_level", int'(rx_level), m_rxq.size());
    if (m_rxq.size() > 0) check1("R6", "rx_rdata", int'(rx_rdata), int'(m_rxq[0]));
    check1("R9", "irq",         int'(irq),         int'(m_irq_rx | m_irq_tx));
    check1("R7", "tx_underrun", int'(tx_underrun), int'(m_und));
    check1("R8", "rx_overflow", int'(rx_overflow), int'(m_ovf));
  endtask

  task automatic model_step();
    bit tx_was_full, rx_was_full, rx_was_empty, popped, und_ev, pushed, drop;
    int p, idx;
    popped = 0; und_ev = 0; pushed = 0; drop = 0;
    if (!enable) begin
      m_txq.delete(); m_rxq.delete(); m_k = 0;
      m_sclk = 0; m_sync = 0; m_dout = 0;
      m_irq_rx = 0; m_irq_tx = 0; m_und = 0; m_ovf = 0;
      return;
    end
    tx_was_full  = (m_txq.size() == QDEPTH);
    rx_was_full  = (m_rxq.size() == QDEPTH);
    rx_was_empty = (m_rxq.size() == 0);
    if (!(rx_enable && tx_enable)) begin
      m_k = 0; m_sclk = 0; m_sync = 0; m_dout = 0;
    end else if (bit_tick) begin
      if (m_k % 2 == 0) begin
        p = m_k / 2;
        m_sclk = 1;
        m_sync = (p % 8 == 0);
        if (p == 0) m_dout = 0;
        else begin
          idx = (p - 1) % 8;
          if (idx == 0) begin
            if (m_txq.size() > 0) begin m_cur = m_txq.pop_front(); popped = 1; end
            else begin m_cur = 8'hFF; und_ev = 1; end
          end
          m_dout = m_cur[7-idx];
        end
      end else begin
        p = (m_k - 1) / 2;
        m_sclk = 0;
        if (p >= 1) begin
          idx = (p - 1) % 8;
          m_rxb[7-idx] = pcm_din;
          if (idx == 7) begin
            if (rx_was_full) drop = 1; else pushed = 1;
          end
        end
      end
      m_k++;
    end
    if (tx_wr && !tx_was_full) m_txq.push_back(tx_wdata);
    if (rx_rd && !rx_was_empty) void'(m_rxq.pop_front());
    if (pushed) m_rxq.push_back(m_rxb);
    m_irq_rx = (pushed && m_rxq.size() == QHALF) ||
               (m_irq_rx && !(irq_ack || m_rxq.size() < QHALF));
    m_irq_tx = (popped && m_txq.size() == QHALF) ||
               (m_irq_tx && !(irq_ack || m_txq.size() > QHALF));
    m_und = und_ev || (m_und && !irq_ack);
    m_ovf = drop   || (m_ovf && !irq_ack);
  endtask

  // one clock: set strobe/data, advance model, pass edge, compare
  task automatic step();
    bit_tick = (cyc % TICK_DIV == 0);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    pcm_din = lfsr[0];
    model_step();
    @(negedge clk);
    compare_all();
    cyc++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic write_byte(logic [7:0] v);
    tx_wr = 1; tx_wdata = v; step(); tx_wr = 0;
  endtask

  task automatic read_byte();
    rx_rd = 1; step(); rx_rd = 0;
  endtask

  task automatic pulse_ack();
    irq_ack = 1; step(); irq_ack = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    check1("R1", "reset tx_level", int'(tx_level), 0);
    check1("R1", "reset irq", int'(irq), 0);
    idle(2);
    // R1: write while disabled is ignored
    write_byte(8'hAA);
    check1("R1", "tx_level after disabled write", int'(tx_level), 0);
    // enable without link; preload 12 bytes
    enable = 1;
    for (int i = 0; i < 12; i++) write_byte(8'(i * 17 + 3));
    check1("R2", "tx_level preload", int'(tx_level), 12);
    // R4: only one direction enabled -> serial idle, contents kept
    rx_enable = 1;
    idle(40);
    check1("R4", "pcm_clk with tx off", int'(pcm_clk), 0);
    check1("R4", "tx_level kept", int'(tx_level), 12);
    // link up: drain (R9 tx), underrun (R7), fill rx (R9 rx, R8)
    tx_enable = 1;
    idle(400);
    pulse_ack();
    idle(500);
    idle(300);
    for (int i = 0; i < 10; i++) read_byte();
    idle(20);
    // stop link mid-frame, then R10 acknowledge
    tx_enable = 0;
    step();
    pulse_ack();
    check1("R10", "underrun after ack", int'(tx_underrun), 0);
    check1("R10", "overflow after ack", int'(rx_overflow), 0);
    check1("R10", "irq after ack", int'(irq), 0);
    // R2: overfill the transmit queue while link is off
    for (int i = 0; i < 17; i++) write_byte(8'(8'h40 + i));
    check1("R2", "tx_level capped", int'(tx_level), 16);
    // restart with lead-in (R5)
    tx_enable = 1;
    idle(300);
    // R1: global disable clears
    enable = 0;
    step();
    check1("R1", "tx_level after disable", int'(tx_level), 0);
    check1("R1", "rx_level after disable", int'(rx_level), 0);
    idle(4);
    done = 1;
    finish_run();
  end

endmodule